// File: doc/BRIEF.md
# Glitch-Filtered GPIO Port Controller

This block is a parameterised general-purpose I/O port. It controls `N_PINS` pads through a simple synchronous register bus. A set of per-pin control registers decides, for each pin, four things:
- whether the port or a peripheral owns the pin;
- whether the output driver is on;
- which level is driven;
- whether the pad pull-up is engaged.

Every pad input passes through a two-flop synchronizer before any use. The synchronized level goes straight to the peripheral side and to a readable pin-value register. To save power, a pin-value bit samples only while its pin is port-owned or has its interrupt enabled; otherwise it keeps its last value.

The interrupt path can take each pin through an optional glitch filter. Each filter is a four-state machine: `FLT_LO`, `FLT_LO_CHK`, `FLT_HI` and `FLT_HI_CHK`. The filtered level is high in `FLT_HI` and `FLT_HI_CHK`. Its transitions are:
- `FLT_LO` to `FLT_LO_CHK` when a high sample arrives.
- `FLT_LO_CHK` to `FLT_HI` when the next sample is also high, or back to `FLT_LO` when it is low.
- `FLT_HI` to `FLT_HI_CHK` when a low sample arrives.
- `FLT_HI_CHK` to `FLT_LO` when the next sample is also low, or back to `FLT_HI` when it is high.

The filtered level therefore moves only when two consecutive synchronized samples both disagree with it, which adds two cycles of delay.

For an interrupt-enabled pin, either edge of the selected interrupt source sets a sticky flag. The single interrupt output is the OR of all flags whose enable is set.

Register word addresses on `bus_addr`:

| Address | Register | Access |
|---|---|---|
| 0 | ownership | read/write |
| 1 | driver enable | read/write |
| 2 | output value | read/write |
| 3 | set alias | write only, reads 0 |
| 4 | clear alias | write only, reads 0 |
| 5 | pull-up | read/write |
| 6 | filter enable | read/write |
| 7 | interrupt enable | read/write |
| 8 | pin value | read only |
| 9 | interrupt flags | read, write-one-to-clear |

Bit i of every register belongs to pin i. Reads return data combinationally while `bus_sel` is high. Any other address reads zero.

Top module: `gpio_port`

## Requirements
- R1: After reset, every register at addresses 0 through 9 reads zero and `irq` is low.
- R2: Where the ownership bit is 1, `pad_out` and `pad_oe` follow the output-value and driver-enable registers. Where it is 0, they follow `periph_out` and `periph_oe`.
- R3: A write to address 2 loads the output value whole. Writing a 1 to a bit at address 3 sets that output bit, and writing a 1 at address 4 clears it; 0 bits leave the output unchanged. All three take effect on `pad_out` at the clock edge that accepts the write.
- R4: `pad_pu` equals the pull-up register, whatever the ownership bit.
- R5: For a pin whose ownership or interrupt-enable bit is 1, the pin-value register shows the pad level three clock edges after the pad changes.
- R6: For a pin whose ownership and interrupt-enable bits are both 0, the pin-value bit holds its previous value.
- R7: `periph_in` shows the pad level two clock edges after it changes, unaffected by the filter setting.
- R8: With the filter enabled, a pad pulse lasting one clock period sets no flag, and a pulse lasting two clock periods sets the flag.
- R9: Without the filter, a pad edge on an enabled pin sets its flag at the third clock edge. With the filter, the flag is set at the fifth clock edge.
- R10: Both rising and falling edges set the flag of an interrupt-enabled pin. A pin whose interrupt enable is 0 never gets its flag set.
- R11: Writing a 1 to a flag bit at address 9 clears it, and writing 0 leaves it. A new edge arriving in the same cycle as a clear leaves the flag set.
- R12: `irq` is high exactly when some flag is set whose interrupt enable is also set. Clearing the enable masks a pending flag without erasing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | N_PINS | Write data, one bit per pin |
| bus_rdata | output | N_PINS | Read data for the selected address |
| pad_in | input | N_PINS | Asynchronous pad levels |
| periph_out | input | N_PINS | Peripheral output levels for unowned pins |
| periph_oe | input | N_PINS | Peripheral driver enables for unowned pins |
| pad_out | output | N_PINS | Level driven to the pads |
| pad_oe | output | N_PINS | Pad driver enables |
| pad_pu | output | N_PINS | Pad pull-up enables |
| periph_in | output | N_PINS | Synchronized pad levels for peripherals |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume three things about the inputs:
- Reset is held for at least two clock edges, so the synchronizer and filter states start at zero.
- A bus write presents its address and data stable across the accepting edge.
- Only one register access happens per cycle.

The pad inputs may change at any time. The filter and pin-value properties only reason about the synchronized samples, so they do not depend on pad timing. The stimulus changes pads and bus signals only at falling clock edges and holds each write for exactly one rising edge. This makes every latency count, the one-cycle glitch and the coinciding clear-and-set case land on known edges.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Register word addresses
    typedef enum logic [3:0] {
        RA_OWN  = 4'd0,
        RA_DRV  = 4'd1,
        RA_OUT  = 4'd2,
        RA_SET  = 4'd3,
        RA_CLR  = 4'd4,
        RA_PULL = 4'd5,
        RA_FILT = 4'd6,
        RA_IEN  = 4'd7,
        RA_PIN  = 4'd8,
        RA_FLAG = 4'd9
    } reg_addr_e;

    // Glitch-filter states; bit 1 is the filtered level
    typedef enum logic [1:0] {
        FLT_LO     = 2'b00,
        FLT_LO_CHK = 2'b01,
        FLT_HI     = 2'b11,
        FLT_HI_CHK = 2'b10
    } flt_state_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] pad_i,
    input  logic [N_PINS-1:0] samp_en_i,
    output logic [N_PINS-1:0] sync_o,
    output logic [N_PINS-1:0] pin_o
);

    logic [N_PINS-1:0] meta_q;
    logic [N_PINS-1:0] sync_q;
    logic [N_PINS-1:0] pin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            pin_q  <= '0;
        end else begin
            meta_q <= pad_i;
            sync_q <= meta_q;
            pin_q  <= (sync_q & samp_en_i) | (pin_q & ~samp_en_i);
        end
    end

    assign sync_o = sync_q;
    assign pin_o  = pin_q;

    // R6
    pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_q ^ $past(pin_q)) & ~$past(samp_en_i)) == '0);

endmodule

// File: rtl/gpio_glitch_filter.sv
module gpio_glitch_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic samp_i,
    output logic filt_o
);
    import gpio_pkg::*;

    flt_state_e state_q;
    flt_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLT_LO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLT_LO:     if (samp_i) state_d = FLT_LO_CHK;
            FLT_LO_CHK: state_d = samp_i ? FLT_HI : FLT_LO;
            FLT_HI:     if (!samp_i) state_d = FLT_HI_CHK;
            FLT_HI_CHK: state_d = samp_i ? FLT_HI : FLT_LO;
            default:    state_d = FLT_LO;
        endcase
    end

    always_comb begin
        filt_o = (state_q == FLT_HI) || (state_q == FLT_HI_CHK);
    end

    // R8
    flt_rise_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(filt_o) |-> ($past(samp_i) && $past(samp_i, 2)));

    // R8
    flt_fall_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(filt_o) |-> (!$past(samp_i) && !$past(samp_i, 2)));

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] sync_i,
    input  logic [N_PINS-1:0] filt_en_i,
    input  logic [N_PINS-1:0] ien_i,
    input  logic [N_PINS-1:0] clr_i,
    output logic [N_PINS-1:0] flags_o,
    output logic              irq_o
);

    logic [N_PINS-1:0] filt_w;
    logic [N_PINS-1:0] src_w;
    logic [N_PINS-1:0] edge_w;
    logic [N_PINS-1:0] prev_q;
    logic [N_PINS-1:0] flags_q;

    for (genvar g = 0; g < N_PINS; g++) begin : g_flt
        gpio_glitch_filter u_flt (
            .clk    (clk),
            .rst_n  (rst_n),
            .samp_i (sync_i[g]),
            .filt_o (filt_w[g])
        );
    end

    assign src_w  = (filt_w & filt_en_i) | (sync_i & ~filt_en_i);
    assign edge_w = (src_w ^ prev_q) & ien_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= '0;
            flags_q <= '0;
        end else begin
            prev_q  <= src_w;
            flags_q <= (flags_q & ~clr_i) | edge_w;
        end
    end

    assign flags_o = flags_q;
    assign irq_o   = |(flags_q & ien_i);

    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flags_q) & ~$past(clr_i)) & ~flags_q) == '0);

    // R10
    flag_needs_ien_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q & ~$past(flags_q) & ~$past(ien_i)) == '0);

endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
    parameter int N_PINS = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N_PINS-1:0] bus_wdata,
    output logic [N_PINS-1:0] bus_rdata,
    input  logic [N_PINS-1:0] pad_in,
    input  logic [N_PINS-1:0] periph_out,
    input  logic [N_PINS-1:0] periph_oe,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe,
    output logic [N_PINS-1:0] pad_pu,
    output logic [N_PINS-1:0] periph_in,
    output logic              irq
);
    import gpio_pkg::*;

    localparam logic [ADDR_W-1:0] A_OWN  = ADDR_W'(RA_OWN);
    localparam logic [ADDR_W-1:0] A_DRV  = ADDR_W'(RA_DRV);
    localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(RA_OUT);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(RA_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(RA_CLR);
    localparam logic [ADDR_W-1:0] A_PULL = ADDR_W'(RA_PULL);
    localparam logic [ADDR_W-1:0] A_FILT = ADDR_W'(RA_FILT);
    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(RA_IEN);
    localparam logic [ADDR_W-1:0] A_PIN  = ADDR_W'(RA_PIN);
    localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(RA_FLAG);

    logic              wr_en;
    logic [N_PINS-1:0] own_q, drv_q, out_q, pull_q, filt_q, ien_q;
    logic [N_PINS-1:0] sync_w, pin_w, flags_w, clr_w;

    assign wr_en = bus_sel && bus_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_q  <= '0;
            drv_q  <= '0;
            out_q  <= '0;
            pull_q <= '0;
            filt_q <= '0;
            ien_q  <= '0;
        end else if (wr_en) begin
            if (bus_addr == A_OWN)  own_q  <= bus_wdata;
            if (bus_addr == A_DRV)  drv_q  <= bus_wdata;
            if (bus_addr == A_PULL) pull_q <= bus_wdata;
            if (bus_addr == A_FILT) filt_q <= bus_wdata;
            if (bus_addr == A_IEN)  ien_q  <= bus_wdata;
            if (bus_addr == A_OUT)      out_q <= bus_wdata;
            else if (bus_addr == A_SET) out_q <= out_q | bus_wdata;
            else if (bus_addr == A_CLR) out_q <= out_q & ~bus_wdata;
        end
    end

    assign clr_w = (wr_en && bus_addr == A_FLAG) ? bus_wdata : '0;

    gpio_in_sync #(.N_PINS(N_PINS)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pad_i     (pad_in),
        .samp_en_i (own_q | ien_q),
        .sync_o    (sync_w),
        .pin_o     (pin_w)
    );

    gpio_irq_unit #(.N_PINS(N_PINS)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_i    (sync_w),
        .filt_en_i (filt_q),
        .ien_i     (ien_q),
        .clr_i     (clr_w),
        .flags_o   (flags_w),
        .irq_o     (irq)
    );

    assign pad_out   = (out_q & own_q) | (periph_out & ~own_q);
    assign pad_oe    = (drv_q & own_q) | (periph_oe & ~own_q);
    assign pad_pu    = pull_q;
    assign periph_in = sync_w;

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                A_OWN:   bus_rdata = own_q;
                A_DRV:   bus_rdata = drv_q;
                A_OUT:   bus_rdata = out_q;
                A_PULL:  bus_rdata = pull_q;
                A_FILT:  bus_rdata = filt_q;
                A_IEN:   bus_rdata = ien_q;
                A_PIN:   bus_rdata = pin_w;
                A_FLAG:  bus_rdata = flags_w;
                default: bus_rdata = '0;
            endcase
        end
    end

    // R3
    set_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == A_SET) |=> ((out_q & $past(bus_wdata)) == $past(bus_wdata)));

    // R3
    clr_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == A_CLR) |=> ((out_q & $past(bus_wdata)) == '0));

endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;

    localparam int N = 8;
    localparam int AW = 4;
    // {addr[3:0], wdata[7:0], expected output value[7:0]}
    localparam logic [19:0] VEC [0:7] = '{
        20'h2_A5_A5, 20'h3_0F_AF, 20'h4_A0_0F, 20'h3_00_0F,
        20'h4_FF_00, 20'h2_3C_3C, 20'h3_C3_FF, 20'h4_81_7E
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0, bus_rdata;
    logic [N-1:0]  pad_in = '0, periph_out = '0, periph_oe = '0;
    logic [N-1:0]  pad_out, pad_oe, pad_pu, periph_in;
    logic          irq;
    int            total = 0, bad = 0;
    logic          done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_port #(.N_PINS(N), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .periph_out(periph_out), .periph_oe(periph_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .periph_in(periph_in), .irq(irq)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [AW-1:0] a, input logic [N-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_sel = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [N-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #0.5;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] d;
        waitn(4);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 10; a++) begin
            rd(AW'(a), d);
            chk("R1 register zero", d, '0);
        end
        chk("R1 irq low", {7'd0, irq}, '0);

        // R2 ownership mux
        periph_out = 8'h5A; periph_oe = 8'hF0;
        #0.5;
        chk("R2 periph out", pad_out, 8'h5A);
        chk("R2 periph oe", pad_oe, 8'hF0);
        @(negedge clk);
        wr(4'd1, 8'h0F);
        wr(4'd2, 8'h33);
        chk("R2 unowned oe", pad_oe, 8'hF0);
        wr(4'd0, 8'hFF);
        chk("R2 owned out", pad_out, 8'h33);
        chk("R2 owned oe", pad_oe, 8'h0F);
        wr(4'd0, 8'h0F);
        chk("R2 mixed out", pad_out, 8'h53);
        chk("R2 mixed oe", pad_oe, 8'hFF);
        wr(4'd0, 8'hFF);

        // R3 table of output-value writes
        for (int k = 0; k < 8; k++) begin
            wr(VEC[k][19:16], VEC[k][15:8]);
            chk("R3 pad_out", pad_out, VEC[k][7:0]);
            rd(4'd2, d);
            chk("R3 readback", d, VEC[k][7:0]);
            @(negedge clk);
        end
        rd(4'd3, d);
        chk("R3 set alias reads zero", d, '0);

        // R4 pull-up independent of ownership
        wr(4'd5, 8'h96);
        chk("R4 owned", pad_pu, 8'h96);
        wr(4'd0, 8'h00);
        chk("R4 unowned", pad_pu, 8'h96);
        wr(4'd0, 8'hFF);

        // R5 / R7 input latency
        pad_in = 8'hC3;
        @(negedge clk);
        chk("R7 one edge", periph_in, 8'h00);
        @(negedge clk);
        chk("R7 two edges", periph_in, 8'hC3);
        rd(4'd8, d);
        chk("R5 two edges", d, 8'h00);
        @(negedge clk);
        rd(4'd8, d);
        chk("R5 three edges", d, 8'hC3);

        // R6 sampling gated off
        wr(4'd0, 8'h0F);
        pad_in = 8'h3C;
        waitn(4);
        rd(4'd8, d);
        chk("R6 hold", d, 8'hCC);
        rd(4'd9, d);
        chk("R10 no flag without enable", d, 8'h00);
        wr(4'd7, 8'h30);
        waitn(4);
        rd(4'd8, d);
        chk("R6 ien enables sampling", d, 8'hFC);
        rd(4'd9, d);
        chk("R10 enabling adds no flag", d, 8'h00);

        // R9 / R10 unfiltered edges
        wr(4'd7, 8'h01);
        pad_in = 8'h3F;   // bit0 rises, bit1 rises (not enabled)
        waitn(2);
        rd(4'd9, d);
        chk("R9 unfiltered two edges", d, 8'h00);
        @(negedge clk);
        rd(4'd9, d);
        chk("R9 unfiltered three edges", d, 8'h01);
        chk("R12 irq high", {7'd0, irq}, 8'h01);
        wr(4'd9, 8'h00);
        rd(4'd9, d);
        chk("R11 zero write keeps", d, 8'h01);
        wr(4'd9, 8'h01);
        rd(4'd9, d);
        chk("R11 one write clears", d, 8'h00);
        chk("R12 irq low", {7'd0, irq}, 8'h00);
        pad_in = 8'h3E;   // bit0 falls
        waitn(3);
        rd(4'd9, d);
        chk("R10 falling edge", d, 8'h01);
        wr(4'd9, 8'hFF);

        // R8 filtered pulses
        wr(4'd6, 8'h01);
        pad_in = 8'h3F;
        @(negedge clk);
        pad_in = 8'h3E;
        waitn(6);
        rd(4'd9, d);
        chk("R8 one-cycle pulse rejected", d, 8'h00);
        pad_in = 8'h3F;
        waitn(2);
        pad_in = 8'h3E;
        waitn(8);
        rd(4'd9, d);
        chk("R8 two-cycle pulse accepted", d, 8'h01);
        wr(4'd9, 8'hFF);

        // R9 filtered latency, R7 unaffected
        pad_in = 8'h3F;
        waitn(2);
        chk("R7 filter bypassed", periph_in, 8'h3F);
        waitn(2);
        rd(4'd9, d);
        chk("R9 filtered four edges", d, 8'h00);
        @(negedge clk);
        rd(4'd9, d);
        chk("R9 filtered five edges", d, 8'h01);

        // R11 set wins over clear
        wr(4'd6, 8'h00);
        wr(4'd9, 8'hFF);
        pad_in = 8'h3E;
        waitn(2);
        wr(4'd9, 8'h01);
        rd(4'd9, d);
        chk("R11 set beats clear", d, 8'h01);

        // R12 masking
        wr(4'd7, 8'h00);
        chk("R12 masked", {7'd0, irq}, 8'h00);
        rd(4'd9, d);
        chk("R12 flag kept", d, 8'h01);
        wr(4'd7, 8'h01);
        chk("R12 unmasked", {7'd0, irq}, 8'h01);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule